// File: doc/BRIEF.md
# Per-Pin Interrupt Detector for a 32-Pin Port

This block watches the synchronized levels of a port of general-purpose pins and raises one shared interrupt line when any pin meets the condition chosen for it. Each pin owns a control word in which a 4-bit detection code selects one of five trigger conditions: a rising edge, a falling edge, either edge, a held low level or a held high level. It can also select nothing at all. A match latches a per-pin pending flag. The shared line stays high while any flag is pending.

Software reaches the block through a simple register bus with write strobe, address and write data, and a read path that answers in the same cycle. A service routine reads the pending word, handles each set bit and clears it by writing a one to that bit position. Writing zero to a pin's control word disables that pin. Writing the code back enables it again.

Top module: `pin_irq_unit`

## Requirements
- R1: In reset, every detection code and every pending flag is cleared to zero, so `irq_out` is low and all registers read zero.
- R2: The control word for pin n sits at byte address 4*n. Its detection code occupies bits 19:16. These four bits read back as written, and every other bit reads zero.
- R3: Code 0x9 (rising edge) sets the pin's flag one clock after a cycle in which the pin is 1 and its sample from the previous clock was 0.
- R4: Code 0xA (falling edge) sets the flag when the pin is 0 and its previous sample was 1. A rising edge does not set it.
- R5: Code 0xB (either edge) sets the flag whenever the pin differs from its previous sample.
- R6: Code 0x8 (low level) sets the flag on every clock in which the pin is 0, so a clear has no lasting effect while the pin stays low.
- R7: Code 0xC (high level) sets the flag on every clock in which the pin is 1.
- R8: Code 0x0 and every code outside {0x8, 0x9, 0xA, 0xB, 0xC} never set a flag.
- R9: The pending word is at byte address 0xA0, with bit n for pin n. A write clears each flag whose bit in the write data is 1 and leaves the flags whose bit is 0 unchanged.
- R10: When a flag gets a set condition and a clear write in the same clock, it ends up set.
- R11: `irq_out` is high exactly when at least one pending flag is set.
- R12: Addresses that are neither an aligned control word (4*n, n below 32) nor 0xA0 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | 32 | Synchronized pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| irq_out | output | 1 | Shared interrupt, high while any flag is pending |

## Verification
The bench clears a level-triggered flag while its pin still holds the level. A design that honoured the clear would drop the interrupt even though the condition persists. It also lands an edge on the same clock as the clear of that edge's flag, where a clear-wins design would lose the event. Edges that do not match the selected direction must leave the flag alone, so a design that detects the wrong edge gets caught. Undefined codes, unaligned and unmapped addresses, a clear of one bit beside another pending bit, and the highest pin are also exercised, because a decoder that is too loose or a write that clears the wrong bits would show up there.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [3:0] {
    DET_OFF  = 4'h0,
    DET_LOW  = 4'h8,
    DET_RISE = 4'h9,
    DET_FALL = 4'hA,
    DET_BOTH = 4'hB,
    DET_HIGH = 4'hC
  } det_mode_e;

  // Trigger condition for one pin given the code, the current and the previous level.
  function automatic logic det_hit(input logic [3:0] code, input logic now_lvl,
                                   input logic old_lvl);
    logic hit;
    case (code)
      DET_LOW:  hit = !now_lvl;
      DET_RISE: hit = now_lvl && !old_lvl;
      DET_FALL: hit = !now_lvl && old_lvl;
      DET_BOTH: hit = now_lvl ^ old_lvl;
      DET_HIGH: hit = now_lvl;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic code_valid(input logic [3:0] code);
    return (code == DET_LOW) || (code == DET_RISE) || (code == DET_FALL) ||
           (code == DET_BOTH) || (code == DET_HIGH);
  endfunction

endpackage

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg #(
  parameter int NUM_PINS = 32,
  parameter int CODE_W   = 4,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [CODE_W-1:0]                wr_code,
  output logic [NUM_PINS-1:0][CODE_W-1:0]  cfg_q
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        cfg_q[i] <= wr_code;
      end
    end
  end

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CODE_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PINS-1:0]              pin_lvl,
  input  logic [NUM_PINS-1:0][CODE_W-1:0]  cfg_q,
  output logic [NUM_PINS-1:0]              hit_vec
);

  logic [NUM_PINS-1:0] prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) prev_lvl <= '0;
    else     prev_lvl <= pin_lvl;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_det
    assign hit_vec[i] = det_hit(4'(cfg_q[i]), pin_lvl[i], prev_lvl[i]);
  end

endmodule

// File: rtl/pin_irq_flags.sv
module pin_irq_flags #(
  parameter int NUM_PINS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  set_vec,
  input  logic [NUM_PINS-1:0]  clr_vec,
  output logic [NUM_PINS-1:0]  flags_q
);

  // A set in the same clock as a clear wins.
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit #(
  parameter int               NUM_PINS  = 32,
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 32,
  parameter int               CODE_W    = 4,
  parameter int               CODE_LSB  = 16,
  parameter logic [7:0]       STAT_ADDR = 8'hA0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pin_lvl,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_out
);

  localparam int              IDX_W   = $clog2(NUM_PINS);
  localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(NUM_PINS * 4);
  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);

  function automatic logic [DATA_W-1:0] place_code(input logic [CODE_W-1:0] code);
    return DATA_W'(code) << CODE_LSB;
  endfunction

  function automatic logic [CODE_W-1:0] take_code(input logic [DATA_W-1:0] word);
    return CODE_W'(word >> CODE_LSB);
  endfunction

  logic                            cfg_sel;
  logic                            stat_sel;
  logic                            cfg_wr;
  logic [IDX_W-1:0]                pin_idx;
  logic [NUM_PINS-1:0][CODE_W-1:0] cfg_q;
  logic [NUM_PINS-1:0]             set_vec;
  logic [NUM_PINS-1:0]             clr_vec;
  logic [NUM_PINS-1:0]             flags_q;

  assign cfg_sel  = (reg_addr < CFG_END) && (reg_addr[1:0] == 2'b00);
  assign stat_sel = (reg_addr == STAT_A);
  assign pin_idx  = reg_addr[IDX_W+1:2];
  assign cfg_wr   = reg_wr && cfg_sel;
  assign clr_vec  = (reg_wr && stat_sel) ? reg_wdata[NUM_PINS-1:0] : '0;

  pin_irq_cfg #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .wr_idx  (pin_idx),
    .wr_code (take_code(reg_wdata)),
    .cfg_q   (cfg_q)
  );

  pin_irq_detect #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) u_det (
    .clk     (clk),
    .rst     (rst),
    .pin_lvl (pin_lvl),
    .cfg_q   (cfg_q),
    .hit_vec (set_vec)
  );

  pin_irq_flags #(.NUM_PINS(NUM_PINS)) u_flg (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q)
  );

  always_comb begin
    if (cfg_sel)       reg_rdata = place_code(cfg_q[pin_idx]);
    else if (stat_sel) reg_rdata = DATA_W'(flags_q);
    else               reg_rdata = '0;
  end

  assign irq_out = |flags_q;

endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk
  import pin_irq_pkg::*;
#(
  parameter int         NUM_PINS  = 32,
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 32,
  parameter int         CODE_W    = 4,
  parameter logic [7:0] STAT_ADDR = 8'hA0
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_PINS-1:0]              pin_lvl,
  input logic [ADDR_W-1:0]                reg_addr,
  input logic [DATA_W-1:0]                reg_rdata,
  input logic                             irq_out,
  input logic [NUM_PINS-1:0][CODE_W-1:0]  cfg_q,
  input logic [NUM_PINS-1:0]              set_vec,
  input logic [NUM_PINS-1:0]              clr_vec,
  input logic [NUM_PINS-1:0]              flags_q
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags_q == '0) && !irq_out);

  a_r11_irq_matches_status: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(STAT_ADDR)) |-> (irq_out == (reg_rdata != '0)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags_q[i]);

    a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);

    a_r9_flag_holds: assert property (@(posedge clk) disable iff (rst)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flags_q[i]));

    a_r8_off_silent: assert property (@(posedge clk) disable iff (rst)
      !code_valid(4'(cfg_q[i])) |-> !set_vec[i]);

    a_r3_rise_detected: assert property (@(posedge clk) disable iff (rst)
      ((4'(cfg_q[i]) == DET_RISE) && $rose(pin_lvl[i])) |-> set_vec[i]);

    a_r6_low_detected: assert property (@(posedge clk) disable iff (rst)
      ((4'(cfg_q[i]) == DET_LOW) && !pin_lvl[i]) |-> set_vec[i]);
  end

endmodule

bind pin_irq_unit pin_irq_unit_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CODE_W(CODE_W), .STAT_ADDR(STAT_ADDR)
) u_chk (.*);

// File: tb/tb_pin_irq_unit.sv
module tb_pin_irq_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_lvl = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_irq_unit dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  // Behavioural reference model
  logic [3:0]  m_code [32];
  logic [31:0] m_pend = '0;
  logic [31:0] m_last = '0;
  bit          m_live = 0;

  function automatic bit m_trig(input logic [3:0] c, input bit now, input bit was);
    if (c == 4'h8) return !now;
    if (c == 4'h9) return now && !was;
    if (c == 4'hA) return !now && was;
    if (c == 4'hB) return now != was;
    if (c == 4'hC) return now;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a < 8'h80 && a % 4 == 0) return {12'h0, m_code[a / 4], 16'h0};
    if (a == 8'hA0) return m_pend;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 32; k++) m_code[k] = 4'h0;
      m_pend = '0;
      m_last = '0;
      m_live = 1;
    end else begin
      logic [31:0] nxt;
      nxt = m_pend;
      if (reg_wr && reg_addr == 8'hA0) nxt = nxt & ~reg_wdata;
      for (int k = 0; k < 32; k++)
        if (m_trig(m_code[k], pin_lvl[k], m_last[k])) nxt[k] = 1'b1;
      m_pend = nxt;
      if (reg_wr && reg_addr < 8'h80 && reg_addr % 4 == 0)
        m_code[reg_addr / 4] = reg_wdata[19:16];
      m_last = pin_lvl;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every clock, compare against the model between edges
  always @(negedge clk) begin
    #5;
    if (!rst && m_live && !done) begin
      check("R11 irq vs model", {31'h0, irq_out}, {31'h0, m_pend != 0});
      check("R9 rdata vs model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #5;
    v = reg_rdata;
  endtask

  task automatic pin(input int n, input bit v);
    @(negedge clk);
    pin_lvl[n] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    rd(8'hA0, v); check("R1 status after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq_out}, 32'h0);
    rd(8'h04, v); check("R1 control after reset", v, 32'h0);
    // R2
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R2 only code bits kept", v, 32'h000F_0000);
    // R8 undefined code 0xF on pin 1
    pin(1, 1); pin(1, 0);
    rd(8'hA0, v); check("R8 undefined code silent", v, 32'h0);
    wr(8'h04, 32'h0);
    // R3 rising on pin 3
    wr(8'h0C, 32'h0009_0000);
    rd(8'h0C, v); check("R2 readback pin3", v, 32'h0009_0000);
    pin(3, 1);
    rd(8'hA0, v); check("R3 rise sets flag", v, 32'h0000_0008);
    check("R11 irq high", {31'h0, irq_out}, 32'h1);
    wr(8'hA0, 32'h0000_0008);
    rd(8'hA0, v); check("R9 clear with pin high edge mode", v, 32'h0);
    check("R11 irq low", {31'h0, irq_out}, 32'h0);
    pin(3, 0);
    rd(8'hA0, v); check("R3 fall ignored", v, 32'h0);
    // R4 falling on pin 5
    wr(8'h14, 32'h000A_0000);
    pin(5, 1);
    rd(8'hA0, v); check("R4 rise ignored", v, 32'h0);
    pin(5, 0);
    rd(8'hA0, v); check("R4 fall sets flag", v, 32'h0000_0020);
    wr(8'hA0, 32'hFFFF_FFFF);
    // R5 either on pin 7
    wr(8'h1C, 32'h000B_0000);
    pin(7, 1);
    rd(8'hA0, v); check("R5 rise sets flag", v, 32'h0000_0080);
    wr(8'hA0, 32'h0000_0080);
    pin(7, 0);
    rd(8'hA0, v); check("R5 fall sets flag", v, 32'h0000_0080);
    wr(8'hA0, 32'h0000_0080);
    rd(8'hA0, v); check("R5 cleared", v, 32'h0);
    // R6 low level on pin 9 (pin at 0)
    wr(8'h24, 32'h0008_0000);
    rd(8'hA0, v); check("R6 low level sets", v, 32'h0000_0200);
    wr(8'hA0, 32'h0000_0200);
    rd(8'hA0, v); check("R6 clear does not stick while low", v, 32'h0000_0200);
    pin(9, 1);
    rd(8'hA0, v); check("R6 flag latched after level gone", v, 32'h0000_0200);
    wr(8'hA0, 32'h0000_0200);
    rd(8'hA0, v); check("R6 clear after level gone", v, 32'h0);
    // R7 high level on pin 12
    wr(8'h30, 32'h000C_0000);
    rd(8'hA0, v); check("R7 no set while low", v, 32'h0);
    pin(12, 1);
    wr(8'hA0, 32'h0000_1000);
    rd(8'hA0, v); check("R7 clear does not stick while high", v, 32'h0000_1000);
    pin(12, 0);
    wr(8'hA0, 32'h0000_1000);
    rd(8'hA0, v); check("R7 clear after level gone", v, 32'h0);
    // R8 code 0x0 and 0x5 on pin 2
    wr(8'h08, 32'h0005_0000);
    pin(2, 1); pin(2, 0);
    rd(8'hA0, v); check("R8 code 5 silent", v, 32'h0);
    wr(8'h08, 32'h0000_0000);
    pin(2, 1); pin(2, 0);
    rd(8'hA0, v); check("R8 code 0 silent", v, 32'h0);
    // R9 selective clear
    @(negedge clk); pin_lvl[3] = 1; pin_lvl[7] = 1;
    rd(8'hA0, v); check("R9 two flags", v, 32'h0000_0088);
    wr(8'hA0, 32'h0000_0008);
    rd(8'hA0, v); check("R9 zero bits untouched", v, 32'h0000_0080);
    @(negedge clk); pin_lvl[3] = 0; pin_lvl[7] = 0;
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, v); check("R9 clear all", v, 32'h0);
    // R10 edge and clear in the same clock
    @(negedge clk);
    pin_lvl[7] = 1; reg_wr = 1'b1; reg_addr = 8'hA0; reg_wdata = 32'h0000_0080;
    @(negedge clk); reg_wr = 1'b0;
    rd(8'hA0, v); check("R10 set wins over clear", v, 32'h0000_0080);
    wr(8'hA0, 32'hFFFF_FFFF);
    // R3 highest pin
    wr(8'h7C, 32'h0009_0000);
    pin(31, 1);
    rd(8'hA0, v); check("R3 pin31 rise", v, 32'h8000_0000);
    wr(8'hA0, 32'hFFFF_FFFF);
    // R12 unmapped and unaligned
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h84, v); check("R12 unmapped reads zero", v, 32'h0);
    wr(8'h0D, 32'h000C_0000);
    rd(8'h0C, v); check("R12 unaligned write ignored", v, 32'h0009_0000);
    rd(8'h0D, v); check("R12 unaligned reads zero", v, 32'h0);
    rd(8'h90, v); check("R12 gap reads zero", v, 32'h0);
    rd(8'hA0, v); check("R12 no flag side effect", v, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule